// File: doc/BRIEF.md
# Selectable-Polynomial PRBS Lane Source

This block produces one lane of pseudo-random test data for a high-speed transmitter. Every clock it delivers a 4-bit parallel word. A later 4:1 serializer turns that word into the line stream. A configuration strobe captures five settings together: which of nine maximal-length feedback polynomials to run, whether to invert the stream, how many sequence bits to skip before output starts, how many times each sequence bit is repeated, and how often a deliberate bit error is inserted.

After a strobe, the generator reloads its all-ones seed. It then advances one sequence bit per clock until the requested phase is reached. During that time the output is flagged invalid. Lanes that run the same polynomial can therefore be shifted against one another by an exact number of bits. Once the phase is reached, the word stream runs without gaps until the next strobe. Configuration inputs that change without a strobe have no effect.

Top module: `prbs_lane_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` and `out_word` are zero. Reset selects these defaults: polynomial code 0, no inversion, repeat factor 1, injection off, offset 0. The first valid word appears on the first rising edge with `rst_n` high.
- R2: The sequence b[n], n >= 0, follows b[n] = XOR of b[n-e] over the polynomial's nonzero exponents e, with b[n] = 1 for every n < 0 (all-ones seed). Codes and exponents:
  - 0: {6,7}
  - 1: {5,9}
  - 2: {7,10}
  - 3: {9,11}
  - 4: {1,2,12,13}
  - 5: {14,15}
  - 6: {3,20}
  - 7: {18,23}
  - 8: {28,31}
- R3: Polynomial codes 9 to 15 select the sequence of code 0.
- R4: Output bit k of the stream (k = 0 for the first valid bit after a strobe) sits in word k/4 at position k%4, so bit 0 goes first on the line. While `out_valid` is high and no strobe arrives, a new valid word is presented on every clock.
- R5: With `cfg_invert` captured as 1, every output bit is the complement of its uninverted value.
- R6: With offset P captured, stream bit k carries sequence bit b[P + k/D] before inversion and error insertion, where D is the repeat factor. `out_valid` first rises on the (P+1)-th rising edge after the edge that captures the strobe. An offset equal to the sequence length gives the same stream as offset 0.
- R7: `cfg_rate` codes map to repeat factors as follows: 0 gives D = 1, 1 gives D = 2, and 2 or 3 give D = 4. Each sequence bit is output D times in a row.
- R8: With period M captured non-zero, stream bits k where (k+1) is a multiple of M are inverted, so exactly one bit in every M is flipped. With M = 0, no bit is flipped.
- R9: On the edge after a strobe, `out_valid` is low, and the error-insertion count restarts. Changes on the `cfg_*` data inputs without a strobe leave the stream unchanged.
- R10: The register never reaches the all-zero state. The stream of code 0 repeats with period exactly 127 and holds 64 ones per period. The stream of code 1 repeats with period exactly 511 and holds 256 ones per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | Strobe that captures all cfg_* inputs and restarts the lane |
| cfg_poly | input | 4 | Polynomial code (0 to 8; higher codes act as 0) |
| cfg_invert | input | 1 | Invert every output bit |
| cfg_offset | input | OFS_W (31) | Number of sequence bits skipped after seeding |
| cfg_rate | input | 2 | Bit-repeat code |
| cfg_err_period | input | ERR_W (16) | Error-insertion period in output bits, 0 = off |
| out_word | output | 4 | Parallel word, bit 0 first on the line |
| out_valid | output | 1 | Word is part of the configured stream |

## Verification
If the state register is wrong, the very next valid word departs from the bit-serial model. A bad tap, seed or step count is caught within one to a few words of the first valid output. A wrong phase-skip count shows up at the port in two ways: the valid flag rises at the wrong time, and the first word is misaligned. A flaw in the error counter appears at the first multiple of the period. A drift in period or balance is exposed by the full-period capture of the two shortest polynomials, one period after start.

// File: rtl/prbs_lane_pkg.sv
// Package: shared constants and polynomial lookup for the PRBS lane source.
// Assumes at most four exponents per polynomial and a longest register of 31 bits.
package prbs_lane_pkg;

    localparam int MAX_L  = 31;
    localparam int WORD_W = 4;
    localparam int POLY_W = 4;

    typedef logic [MAX_L-1:0] lfsr_t;

    // Feedback mask: bit (e-1) is set for each exponent e; unknown codes fall back to code 0.
    function automatic lfsr_t tap_mask(input logic [POLY_W-1:0] code);
        lfsr_t m;
        m = '0;
        case (code)
            4'd1: begin m[4]  = 1'b1; m[8]  = 1'b1; end
            4'd2: begin m[6]  = 1'b1; m[9]  = 1'b1; end
            4'd3: begin m[8]  = 1'b1; m[10] = 1'b1; end
            4'd4: begin m[0] = 1'b1; m[1] = 1'b1; m[11] = 1'b1; m[12] = 1'b1; end
            4'd5: begin m[13] = 1'b1; m[14] = 1'b1; end
            4'd6: begin m[2]  = 1'b1; m[19] = 1'b1; end
            4'd7: begin m[17] = 1'b1; m[22] = 1'b1; end
            4'd8: begin m[27] = 1'b1; m[30] = 1'b1; end
            default: begin m[5] = 1'b1; m[6] = 1'b1; end
        endcase
        return m;
    endfunction

    // Register length for a code, as a mask of the live state bits.
    function automatic lfsr_t len_mask(input logic [POLY_W-1:0] code);
        int l;
        case (code)
            4'd1: l = 9;
            4'd2: l = 10;
            4'd3: l = 11;
            4'd4: l = 13;
            4'd5: l = 15;
            4'd6: l = 20;
            4'd7: l = 23;
            4'd8: l = 31;
            default: l = 7;
        endcase
        return lfsr_t'((64'd1 << l) - 64'd1);
    endfunction

endpackage

// File: rtl/prbs_step_unit.sv
// Combinational look-ahead: computes the next WORD_W sequence bits and the states
// reached after each step. Assumes state[0] holds the newest sequence bit.
module prbs_step_unit
    import prbs_lane_pkg::*;
(
    input  lfsr_t              state_i,
    input  lfsr_t              taps_i,
    output logic [WORD_W-1:0]  bits_o,
    output lfsr_t              st1_o,
    output lfsr_t              st2_o,
    output lfsr_t              st4_o
);

    lfsr_t chain [WORD_W+1];

    assign chain[0] = state_i;

    // One feedback step per stage; the new bit enters at the low end.
    for (genvar i = 0; i < WORD_W; i++) begin : g_step
        assign bits_o[i]  = ^(chain[i] & taps_i);
        assign chain[i+1] = {chain[i][MAX_L-2:0], bits_o[i]};
    end

    assign st1_o = chain[1];
    assign st2_o = chain[2];
    assign st4_o = chain[WORD_W];

endmodule

// File: rtl/prbs_err_mask.sv
// Error-insertion counter: marks which bits of the current word are flipped so that
// the M-th, 2M-th ... output bits after a restart are inverted. Assumes the period
// only changes in the same cycle as clear_i.
module prbs_err_mask #(
    parameter int ERR_W  = 16,
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              advance_i,
    input  logic [ERR_W-1:0]  period_i,
    output logic [WORD_W-1:0] flip_o
);

    logic [ERR_W-1:0] cnt_q;
    logic [ERR_W-1:0] cnt_d;

    // Walk the word bit by bit, flagging the bit that closes each period.
    always_comb begin
        logic [ERR_W-1:0] c;
        c = cnt_q;
        for (int j = 0; j < WORD_W; j++) begin
            flip_o[j] = (period_i != '0) && (c == period_i - ERR_W'(1));
            c = flip_o[j] ? '0 : c + ERR_W'(1);
        end
        cnt_d = (period_i == '0) ? '0 : c;
    end

    // Hold the position within the period across words.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (advance_i) begin
            cnt_q <= cnt_d;
        end
    end

    p_cnt_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i != '0) |-> (cnt_q < period_i));

    p_single_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i >= ERR_W'(WORD_W)) |-> ($countones(flip_o) <= 1));

endmodule

// File: rtl/prbs_lane_gen.sv
// PRBS lane source: captures configuration on a strobe, seeds all ones, skips the
// requested phase one bit per clock with the output invalid, then emits one 4-bit
// word per clock with bit repeat, inversion and periodic error insertion.
// Assumes cfg_* inputs are only meaningful in the strobe cycle.
module prbs_lane_gen
    import prbs_lane_pkg::*;
#(
    parameter int OFS_W = 31,
    parameter int ERR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load,
    input  logic [POLY_W-1:0]    cfg_poly,
    input  logic                 cfg_invert,
    input  logic [OFS_W-1:0]     cfg_offset,
    input  logic [1:0]           cfg_rate,
    input  logic [ERR_W-1:0]     cfg_err_period,
    output logic [WORD_W-1:0]    out_word,
    output logic                 out_valid
);

    localparam lfsr_t SEED = '1;

    logic [POLY_W-1:0] poly_q;
    logic              inv_q;
    logic [1:0]        rate_q;
    logic [ERR_W-1:0]  period_q;
    logic [OFS_W-1:0]  skip_q;
    lfsr_t             state_q;
    lfsr_t             taps;
    lfsr_t             st1, st2, st4;
    logic [WORD_W-1:0] nbits;
    logic [WORD_W-1:0] raw_word;
    logic [WORD_W-1:0] flip;
    lfsr_t             adv_state;
    logic              emit;

    assign taps = tap_mask(poly_q);
    assign emit = (skip_q == '0) && !cfg_load;

    prbs_step_unit u_step (
        .state_i (state_q),
        .taps_i  (taps),
        .bits_o  (nbits),
        .st1_o   (st1),
        .st2_o   (st2),
        .st4_o   (st4)
    );

    prbs_err_mask #(.ERR_W(ERR_W), .WORD_W(WORD_W)) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (cfg_load),
        .advance_i (emit),
        .period_i  (period_q),
        .flip_o    (flip)
    );

    // Spread fresh sequence bits over the word according to the repeat factor.
    always_comb begin
        case (rate_q)
            2'd0:    begin raw_word = nbits;                                  adv_state = st4; end
            2'd1:    begin raw_word = {nbits[1], nbits[1], nbits[0], nbits[0]}; adv_state = st2; end
            default: begin raw_word = {WORD_W{nbits[0]}};                     adv_state = st1; end
        endcase
    end

    // Capture configuration on the strobe; out-of-range polynomial codes become code 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poly_q   <= '0;
            inv_q    <= 1'b0;
            rate_q   <= 2'd0;
            period_q <= '0;
        end else if (cfg_load) begin
            poly_q   <= (cfg_poly > POLY_W'(8)) ? '0 : cfg_poly;
            inv_q    <= cfg_invert;
            rate_q   <= cfg_rate;
            period_q <= cfg_err_period;
        end
    end

    // Seed, skip phase one bit per clock, then produce one word per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEED;
            skip_q    <= '0;
            out_word  <= '0;
            out_valid <= 1'b0;
        end else if (cfg_load) begin
            state_q   <= SEED;
            skip_q    <= cfg_offset;
            out_valid <= 1'b0;
        end else if (skip_q != '0) begin
            state_q   <= st1;
            skip_q    <= skip_q - OFS_W'(1);
            out_valid <= 1'b0;
        end else begin
            state_q   <= adv_state;
            out_word  <= raw_word ^ {WORD_W{inv_q}} ^ flip;
            out_valid <= 1'b1;
        end
    end

    p_load_blanks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (!out_valid && skip_q == $past(cfg_offset)));

    p_stream_continuous_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cfg_load) |=> out_valid);

    p_no_lockup_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q & len_mask(poly_q)) != '0);

    p_skip_counts_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && skip_q != '0) |=> (skip_q == $past(skip_q) - OFS_W'(1)));

endmodule

// File: tb/prbs_lane_gen_tb.sv
`timescale 1ns/1ps
module prbs_lane_gen_tb;

    localparam int OFS_W = 31;
    localparam int ERR_W = 16;
    localparam int NVEC  = 12;
    localparam int MDL_N = 4096;

    typedef struct packed {
        logic [3:0]  poly;
        logic        inv;
        logic [15:0] off;
        logic [1:0]  rate;
        logic [15:0] per;
        logic [7:0]  nwords;
    } vec_t;

    // Stimulus table: polynomial, invert, offset, rate code, error period, words to check.
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  1'b0, 16'd0,   2'd0, 16'd0,   8'd64},
        '{4'd1,  1'b1, 16'd5,   2'd0, 16'd0,   8'd40},
        '{4'd2,  1'b0, 16'd100, 2'd1, 16'd0,   8'd40},
        '{4'd3,  1'b0, 16'd3,   2'd2, 16'd0,   8'd40},
        '{4'd4,  1'b0, 16'd17,  2'd0, 16'd7,   8'd40},
        '{4'd5,  1'b1, 16'd0,   2'd3, 16'd0,   8'd30},
        '{4'd6,  1'b0, 16'd250, 2'd0, 16'd100, 8'd40},
        '{4'd7,  1'b0, 16'd31,  2'd1, 16'd5,   8'd40},
        '{4'd8,  1'b0, 16'd64,  2'd0, 16'd0,   8'd60},
        '{4'd0,  1'b0, 16'd127, 2'd0, 16'd0,   8'd40},
        '{4'd12, 1'b0, 16'd9,   2'd0, 16'd0,   8'd40},
        '{4'd1,  1'b0, 16'd0,   2'd0, 16'd1,   8'd20}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_load = 1'b0;
    logic [3:0]       cfg_poly = '0;
    logic             cfg_invert = 1'b0;
    logic [OFS_W-1:0] cfg_offset = '0;
    logic [1:0]       cfg_rate = '0;
    logic [ERR_W-1:0] cfg_err_period = '0;
    logic [3:0]       out_word;
    logic             out_valid;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;
    bit  mdl [MDL_N];
    bit  cap [2048];

    always #10 clk = ~clk;

    prbs_lane_gen #(.OFS_W(OFS_W), .ERR_W(ERR_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_load       (cfg_load),
        .cfg_poly       (cfg_poly),
        .cfg_invert     (cfg_invert),
        .cfg_offset     (cfg_offset),
        .cfg_rate       (cfg_rate),
        .cfg_err_period (cfg_err_period),
        .out_word       (out_word),
        .out_valid      (out_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Exponent i of polynomial code (0 when absent), written from the requirement table.
    function automatic int expo(input int code, input int i);
        int e [9][4] = '{'{6,7,0,0}, '{5,9,0,0}, '{7,10,0,0}, '{9,11,0,0}, '{1,2,12,13},
                         '{14,15,0,0}, '{3,20,0,0}, '{18,23,0,0}, '{28,31,0,0}};
        return e[code][i];
    endfunction

    // Bit-serial reference: b[n] = XOR of b[n-e], with b[negative] = 1.
    task automatic build_model(input int code, input int n);
        int c;
        c = (code > 8) ? 0 : code;
        for (int k = 0; k < n; k++) begin
            bit b;
            b = 1'b0;
            for (int i = 0; i < 4; i++) begin
                int e;
                e = expo(c, i);
                if (e != 0) b ^= (k - e < 0) ? 1'b1 : mdl[k - e];
            end
            mdl[k] = b;
        end
    endtask

    function automatic int rep(input logic [1:0] rc);
        return (rc == 2'd0) ? 1 : (rc == 2'd1) ? 2 : 4;
    endfunction

    // Pulse the strobe, then scramble the data inputs to show they are ignored (R9).
    task automatic load_cfg(input vec_t v);
        @(negedge clk);
        cfg_load       = 1'b1;
        cfg_poly       = v.poly;
        cfg_invert     = v.inv;
        cfg_offset     = OFS_W'(v.off);
        cfg_rate       = v.rate;
        cfg_err_period = v.per;
        @(negedge clk);
        cfg_load       = 1'b0;
        cfg_poly       = ~v.poly;
        cfg_invert     = ~v.inv;
        cfg_offset     = OFS_W'(777);
        cfg_rate       = ~v.rate;
        cfg_err_period = 16'd3;
    endtask

    // Count negedges from the strobe until valid; returns count (1 already elapsed).
    task automatic wait_valid(output int lat);
        lat = 1;
        while (!out_valid && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int lat, d, m, mism;
        build_model(int'(v.poly), int'(v.off) + int'(v.nwords) * 4 + 4);
        load_cfg(v);
        check(!out_valid, "R9 blank after strobe", out_valid, 0);
        wait_valid(lat);
        check(lat == int'(v.off) + 2, "R6 valid latency", lat, int'(v.off) + 2);
        d = rep(v.rate);
        m = int'(v.per);
        for (int w = 0; w < int'(v.nwords); w++) begin
            logic [3:0] exp_w;
            for (int j = 0; j < 4; j++) begin
                int k;
                k = w * 4 + j;
                exp_w[j] = mdl[int'(v.off) + k / d] ^ v.inv ^ ((m != 0) && ((k + 1) % m == 0));
            end
            mism = (out_word !== exp_w || out_valid !== 1'b1) ? 1 : 0;
            if (mism != 0)
                $display("  vector %0d word %0d", idx, w);
            check(mism == 0, "R2 R3 R4 R5 R7 R8 stream word", int'(out_word), int'(exp_w));
            @(negedge clk);
        end
    endtask

    // Capture nbits of a plain stream and test its period and balance (R10).
    task automatic period_check(input int code, input int per, input int ones);
        vec_t v;
        int lat, cnt, bad;
        v = '{4'(code), 1'b0, 16'd0, 2'd0, 16'd0, 8'd0};
        load_cfg(v);
        wait_valid(lat);
        for (int w = 0; w < (2 * per + 3) / 4 + 1; w++) begin
            for (int j = 0; j < 4; j++) cap[w * 4 + j] = out_word[j];
            @(negedge clk);
        end
        cnt = 0;
        for (int k = 0; k < per; k++) cnt += int'(cap[k]);
        check(cnt == ones, "R10 ones per period", cnt, ones);
        bad = 0;
        for (int k = 0; k < per; k++) if (cap[k] != cap[k + per]) bad++;
        check(bad == 0, "R10 repeats at full period", bad, 0);
        bad = 1;
        for (int k = 0; k < per; k++) if (cap[k] != cap[k + 1]) bad = 0;
        check(bad == 0, "R10 not constant", bad, 0);
    endtask

    // Watchdog: a hung run is a failed check that still reaches the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int lat;
        vec_t v;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        check(out_word == 4'd0, "R1 word in reset", out_word, 0);
        build_model(0, 16);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b1, "R1 valid one edge after reset", out_valid, 1);
        check(out_word == {mdl[3], mdl[2], mdl[1], mdl[0]}, "R1 default first word",
              out_word, {mdl[3], mdl[2], mdl[1], mdl[0]});
        @(negedge clk);
        check(out_word == {mdl[7], mdl[6], mdl[5], mdl[4]}, "R1 default second word",
              out_word, {mdl[7], mdl[6], mdl[5], mdl[4]});

        // Table walk
        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

        // R9: strobe in the middle of a running stream restarts it
        v = '{4'd2, 1'b0, 16'd4, 2'd0, 16'd0, 8'd0};
        load_cfg(v);
        wait_valid(lat);
        check(lat == 6, "R9 mid-stream restart latency", lat, 6);

        // R8: period 0 versus period 1 on the same phase
        run_vec('{4'd3, 1'b0, 16'd2, 2'd0, 16'd0, 8'd8}, 100);
        run_vec('{4'd3, 1'b0, 16'd2, 2'd0, 16'd1, 8'd8}, 101);

        // R10: full-period checks
        period_check(0, 127, 64);
        period_check(1, 511, 256);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule